// File: doc/BRIEF.md
# Fixed-Length Instruction Decoder with Immediate Extension

This block is a purely combinational decoder for a 32-bit, fixed-length, load-store instruction word. It slices the word into its opcode, register, shift-amount, function and immediate fields. It then drives the control bundle that a datapath needs: the ALU operation, register write enable and the destination register number, memory read and write strobes with an access size, branch and branch-sense, jump, link and jump-through-register flags, and the immediate extension mode. It also forms the 32-bit immediate.

Register-to-register operations share opcode 0 and are told apart by the 6-bit function field in the low bits of the word. Every other operation is chosen by the primary opcode alone. The immediate is sign-extended, zero-extended or moved into the upper half, depending on the opcode. Any encoding outside the supported set raises an illegal flag and silences every side-effecting control. The register file, ALU, memory and next-PC logic are all outside this block and consume its outputs in the same cycle.

Top module: `insn_decoder`

## Requirements
- R1: The fields come from fixed bit positions: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], shamt [10:6], funct [5:0].
- R2: When opcode is 0, funct selects the operation: 0x20 add (alu 0), 0x22 subtract (alu 1), 0x24 AND (alu 2), 0x25 OR (alu 3), 0x27 NOR (alu 4), 0x2A signed less-than (alu 5), 0x2B unsigned less-than (alu 6). Each of these writes register rd. Whenever reg_we is low, dst_reg is 0.
- R3: Opcode 0x08 (add immediate, alu 0), 0x0A (signed less-than immediate, alu 5) and 0x0B (unsigned less-than immediate, alu 6) sign-extend the immediate (ext mode 0) and write register rt.
- R4: Opcode 0x0C (AND immediate, alu 2) and 0x0D (OR immediate, alu 3) zero-extend the immediate (ext mode 1, so imm[31:16] is 0) and write register rt.
- R5: Opcode 0x0F places the 16-bit immediate in imm[31:16] and clears imm[15:0] (ext mode 2, alu 7 passes the immediate), and it writes register rt.
- R6: Opcode 0x23 sets mem_rd and writes rt. Opcode 0x2B sets mem_wr and writes nothing. Both use word size (mem_size 2), alu 0 and a sign-extended offset.
- R7: Opcode 0x04 and 0x05 set branch, with branch_ne high only for 0x05. Both use alu 1 and a sign-extended offset, and neither writes a register or memory.
- R8: Opcode 0x02 sets jump. Opcode 0x03 sets jump and link, and it writes register LINK_REG (default 31).
- R9: Opcode 0 with funct 0x08 sets jreg (target taken from rs). It writes no register and touches no memory.
- R10: Any other opcode, or opcode 0 with any other funct, sets illegal. It holds reg_we, mem_rd, mem_wr, branch, branch_ne, jump, link and jreg low, and it gives alu 0, mem_size 0, dst_reg 0 and ext mode 0.
- R11: With HAS_UNSIGNED_CMP = 0, the unsigned less-than forms (funct 0x2B and opcode 0x0B) decode as illegal.
- R12: mem_rd and mem_wr are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| opcode_o | output | 6 | Primary opcode field |
| rs_o | output | 5 | First source register field |
| rt_o | output | 5 | Second source / immediate destination field |
| rd_o | output | 5 | Register-form destination field |
| shamt_o | output | 5 | Shift amount field |
| funct_o | output | 6 | Function field |
| alu_op_o | output | 4 | ALU operation code |
| reg_we_o | output | 1 | Register write enable |
| dst_reg_o | output | 5 | Register number to write |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_size_o | output | 2 | Access size, 2 = word |
| branch_o | output | 1 | Conditional branch |
| branch_ne_o | output | 1 | Branch taken on inequality |
| jump_o | output | 1 | Absolute jump |
| link_o | output | 1 | Save return address |
| jreg_o | output | 1 | Jump through rs |
| ext_mode_o | output | 2 | 0 sign, 1 zero, 2 upper half |
| imm_o | output | 32 | Extended immediate |
| illegal_o | output | 1 | Unsupported encoding |

## Verification
The bench builds two copies side by side on the same instruction stream. The first uses the default parameters: unsigned compares enabled and link register 31. The second has unsigned compares removed and the link register moved to 30. The second copy makes the illegal path of the unsigned forms reachable, and it shows that the jump-and-link destination follows the parameter rather than a fixed number. The stimulus covers each supported operation, negative and positive immediates, and several illegal opcode and function values.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;

   localparam int INSN_W  = 32;
   localparam int OPC_W   = 6;
   localparam int REG_AW  = 5;
   localparam int SHAMT_W = 5;
   localparam int FUNCT_W = 6;
   localparam int IMM_W   = 16;
   localparam int NUM_REGS = 1 << REG_AW;

   localparam int OPC_LSB   = INSN_W - OPC_W;
   localparam int RS_LSB    = OPC_LSB - REG_AW;
   localparam int RT_LSB    = RS_LSB - REG_AW;
   localparam int RD_LSB    = RT_LSB - REG_AW;
   localparam int SHAMT_LSB = RD_LSB - SHAMT_W;

   localparam logic [OPC_W-1:0] OP_REG   = 6'h00;
   localparam logic [OPC_W-1:0] OP_J     = 6'h02;
   localparam logic [OPC_W-1:0] OP_JAL   = 6'h03;
   localparam logic [OPC_W-1:0] OP_BEQ   = 6'h04;
   localparam logic [OPC_W-1:0] OP_BNE   = 6'h05;
   localparam logic [OPC_W-1:0] OP_ADDI  = 6'h08;
   localparam logic [OPC_W-1:0] OP_SLTI  = 6'h0A;
   localparam logic [OPC_W-1:0] OP_SLTIU = 6'h0B;
   localparam logic [OPC_W-1:0] OP_ANDI  = 6'h0C;
   localparam logic [OPC_W-1:0] OP_ORI   = 6'h0D;
   localparam logic [OPC_W-1:0] OP_LUI   = 6'h0F;
   localparam logic [OPC_W-1:0] OP_LW    = 6'h23;
   localparam logic [OPC_W-1:0] OP_SW    = 6'h2B;

   localparam logic [FUNCT_W-1:0] FN_JR   = 6'h08;
   localparam logic [FUNCT_W-1:0] FN_ADD  = 6'h20;
   localparam logic [FUNCT_W-1:0] FN_SUB  = 6'h22;
   localparam logic [FUNCT_W-1:0] FN_AND  = 6'h24;
   localparam logic [FUNCT_W-1:0] FN_OR   = 6'h25;
   localparam logic [FUNCT_W-1:0] FN_NOR  = 6'h27;
   localparam logic [FUNCT_W-1:0] FN_SLT  = 6'h2A;
   localparam logic [FUNCT_W-1:0] FN_SLTU = 6'h2B;

   localparam logic [1:0] SIZE_NONE = 2'd0;
   localparam logic [1:0] SIZE_WORD = 2'd2;

   typedef enum logic [3:0] {
      ALU_ADD  = 4'd0,
      ALU_SUB  = 4'd1,
      ALU_AND  = 4'd2,
      ALU_OR   = 4'd3,
      ALU_NOR  = 4'd4,
      ALU_SLT  = 4'd5,
      ALU_SLTU = 4'd6,
      ALU_PASS = 4'd7
   } alu_e;

   typedef enum logic [1:0] {
      EXT_SIGN  = 2'd0,
      EXT_ZERO  = 2'd1,
      EXT_UPPER = 2'd2
   } ext_e;

   typedef enum logic [1:0] {
      DST_NONE = 2'd0,
      DST_RT   = 2'd1,
      DST_RD   = 2'd2,
      DST_LINK = 2'd3
   } dst_e;

   typedef struct packed {
      alu_e       alu;
      logic       reg_we;
      dst_e       dsel;
      logic       mem_rd;
      logic       mem_wr;
      logic [1:0] mem_size;
      logic       branch;
      logic       branch_ne;
      logic       jump;
      logic       link;
      logic       jreg;
      ext_e       ext;
      logic       illegal;
   } ctrl_t;

endpackage

// File: rtl/insn_fields.sv
module insn_fields
   import insn_dec_pkg::*;
(
   input  logic [INSN_W-1:0]  insn,
   output logic [OPC_W-1:0]   opcode,
   output logic [REG_AW-1:0]  rs,
   output logic [REG_AW-1:0]  rt,
   output logic [REG_AW-1:0]  rd,
   output logic [SHAMT_W-1:0] shamt,
   output logic [FUNCT_W-1:0] funct,
   output logic [IMM_W-1:0]   imm16
);
   assign opcode = insn[OPC_LSB +: OPC_W];
   assign rs     = insn[RS_LSB +: REG_AW];
   assign rt     = insn[RT_LSB +: REG_AW];
   assign rd     = insn[RD_LSB +: REG_AW];
   assign shamt  = insn[SHAMT_LSB +: SHAMT_W];
   assign funct  = insn[0 +: FUNCT_W];
   assign imm16  = insn[0 +: IMM_W];
endmodule

// File: rtl/insn_ctrl.sv
module insn_ctrl
   import insn_dec_pkg::*;
#(
   parameter bit HAS_UNSIGNED_CMP = 1'b1
) (
   input  logic [OPC_W-1:0]   opcode,
   input  logic [FUNCT_W-1:0] funct,
   output ctrl_t              ctrl
);
   logic uns_ok;

   generate
      if (HAS_UNSIGNED_CMP) begin : g_uns
         assign uns_ok = 1'b1;
      end else begin : g_no_uns
         assign uns_ok = 1'b0;
      end
   endgenerate

   ctrl_t raw;

   always_comb begin
      raw          = '0;
      raw.alu      = ALU_ADD;
      raw.dsel     = DST_NONE;
      raw.ext      = EXT_SIGN;
      raw.mem_size = SIZE_NONE;
      unique case (opcode)
         OP_REG: begin
            raw.reg_we = 1'b1;
            raw.dsel   = DST_RD;
            unique case (funct)
               FN_ADD:  raw.alu = ALU_ADD;
               FN_SUB:  raw.alu = ALU_SUB;
               FN_AND:  raw.alu = ALU_AND;
               FN_OR:   raw.alu = ALU_OR;
               FN_NOR:  raw.alu = ALU_NOR;
               FN_SLT:  raw.alu = ALU_SLT;
               FN_SLTU: begin
                  raw.alu     = ALU_SLTU;
                  raw.illegal = !uns_ok;
               end
               FN_JR: begin
                  raw.reg_we = 1'b0;
                  raw.dsel   = DST_NONE;
                  raw.jreg   = 1'b1;
               end
               default: raw.illegal = 1'b1;
            endcase
         end
         OP_ADDI, OP_SLTI, OP_SLTIU, OP_ANDI, OP_ORI, OP_LUI: begin
            raw.reg_we = 1'b1;
            raw.dsel   = DST_RT;
            unique case (opcode)
               OP_SLTI:  raw.alu = ALU_SLT;
               OP_SLTIU: begin
                  raw.alu     = ALU_SLTU;
                  raw.illegal = !uns_ok;
               end
               OP_ANDI: begin
                  raw.alu = ALU_AND;
                  raw.ext = EXT_ZERO;
               end
               OP_ORI: begin
                  raw.alu = ALU_OR;
                  raw.ext = EXT_ZERO;
               end
               OP_LUI: begin
                  raw.alu = ALU_PASS;
                  raw.ext = EXT_UPPER;
               end
               default: raw.alu = ALU_ADD;
            endcase
         end
         OP_LW: begin
            raw.reg_we   = 1'b1;
            raw.dsel     = DST_RT;
            raw.mem_rd   = 1'b1;
            raw.mem_size = SIZE_WORD;
         end
         OP_SW: begin
            raw.mem_wr   = 1'b1;
            raw.mem_size = SIZE_WORD;
         end
         OP_BEQ, OP_BNE: begin
            raw.alu       = ALU_SUB;
            raw.branch    = 1'b1;
            raw.branch_ne = (opcode == OP_BNE);
         end
         OP_J: raw.jump = 1'b1;
         OP_JAL: begin
            raw.jump   = 1'b1;
            raw.link   = 1'b1;
            raw.reg_we = 1'b1;
            raw.dsel   = DST_LINK;
         end
         default: raw.illegal = 1'b1;
      endcase
   end

   always_comb begin
      if (raw.illegal) begin
         ctrl          = '0;
         ctrl.alu      = ALU_ADD;
         ctrl.dsel     = DST_NONE;
         ctrl.ext      = EXT_SIGN;
         ctrl.mem_size = SIZE_NONE;
         ctrl.illegal  = 1'b1;
      end else begin
         ctrl = raw;
      end
   end

   always_comb begin
      if (!$isunknown({opcode, funct})) begin
         assert_branch_no_write_R7: assert (!ctrl.branch || (!ctrl.reg_we && !ctrl.mem_wr && !ctrl.mem_rd))
            else $error("branch decoded with a write side effect");
         assert_jreg_no_write_R9: assert (!ctrl.jreg || (!ctrl.reg_we && !ctrl.mem_wr))
            else $error("register jump decoded with a write side effect");
      end
   end
endmodule

// File: rtl/insn_imm.sv
module insn_imm
   import insn_dec_pkg::*;
(
   input  logic [IMM_W-1:0]  imm16,
   input  ext_e              ext,
   output logic [INSN_W-1:0] imm
);
   localparam int PAD_W = INSN_W - IMM_W;

   always_comb begin
      unique case (ext)
         EXT_ZERO:  imm = {{PAD_W{1'b0}}, imm16};
         EXT_UPPER: imm = {imm16, {PAD_W{1'b0}}};
         default:   imm = {{PAD_W{imm16[IMM_W-1]}}, imm16};
      endcase
   end

   always_comb begin
      if (!$isunknown({imm16, ext})) begin
         assert_upper_low_clear_R5: assert (ext != EXT_UPPER || imm[PAD_W-1:0] == '0)
            else $error("upper-half immediate has nonzero low bits");
         assert_zero_ext_high_R4: assert (ext != EXT_ZERO || imm[INSN_W-1:IMM_W] == '0)
            else $error("zero-extended immediate has nonzero high bits");
      end
   end
endmodule

// File: rtl/insn_decoder.sv
module insn_decoder
   import insn_dec_pkg::*;
#(
   parameter bit HAS_UNSIGNED_CMP = 1'b1,
   parameter int LINK_REG         = 31
) (
   input  logic [31:0] instr_i,
   output logic [5:0]  opcode_o,
   output logic [4:0]  rs_o,
   output logic [4:0]  rt_o,
   output logic [4:0]  rd_o,
   output logic [4:0]  shamt_o,
   output logic [5:0]  funct_o,
   output logic [3:0]  alu_op_o,
   output logic        reg_we_o,
   output logic [4:0]  dst_reg_o,
   output logic        mem_rd_o,
   output logic        mem_wr_o,
   output logic [1:0]  mem_size_o,
   output logic        branch_o,
   output logic        branch_ne_o,
   output logic        jump_o,
   output logic        link_o,
   output logic        jreg_o,
   output logic [1:0]  ext_mode_o,
   output logic [31:0] imm_o,
   output logic        illegal_o
);
   localparam logic [REG_AW-1:0] LINK_IDX = REG_AW'(LINK_REG);

   generate
      if (LINK_REG <= 0 || LINK_REG >= NUM_REGS) begin : g_bad_link
         $error("LINK_REG must name a nonzero register inside the file");
      end
   endgenerate

   logic [IMM_W-1:0] imm16;
   ctrl_t            ctrl;

   insn_fields u_fields (
      .insn   (instr_i),
      .opcode (opcode_o),
      .rs     (rs_o),
      .rt     (rt_o),
      .rd     (rd_o),
      .shamt  (shamt_o),
      .funct  (funct_o),
      .imm16  (imm16)
   );

   insn_ctrl #(.HAS_UNSIGNED_CMP(HAS_UNSIGNED_CMP)) u_ctrl (
      .opcode (opcode_o),
      .funct  (funct_o),
      .ctrl   (ctrl)
   );

   insn_imm u_imm (
      .imm16 (imm16),
      .ext   (ctrl.ext),
      .imm   (imm_o)
   );

   always_comb begin
      unique case (ctrl.dsel)
         DST_RT:   dst_reg_o = rt_o;
         DST_RD:   dst_reg_o = rd_o;
         DST_LINK: dst_reg_o = LINK_IDX;
         default:  dst_reg_o = '0;
      endcase
   end

   assign alu_op_o    = ctrl.alu;
   assign reg_we_o    = ctrl.reg_we;
   assign mem_rd_o    = ctrl.mem_rd;
   assign mem_wr_o    = ctrl.mem_wr;
   assign mem_size_o  = ctrl.mem_size;
   assign branch_o    = ctrl.branch;
   assign branch_ne_o = ctrl.branch_ne;
   assign jump_o      = ctrl.jump;
   assign link_o      = ctrl.link;
   assign jreg_o      = ctrl.jreg;
   assign ext_mode_o  = ctrl.ext;
   assign illegal_o   = ctrl.illegal;

   always_comb begin
      if (!$isunknown(instr_i)) begin
         assert_quiet_on_illegal_R10: assert (!illegal_o ||
               !(reg_we_o | mem_rd_o | mem_wr_o | branch_o | jump_o | link_o | jreg_o))
            else $error("illegal encoding left an enable high");
         assert_link_dest_R8: assert (!link_o || (reg_we_o && dst_reg_o == LINK_IDX))
            else $error("link does not target the link register");
         assert_mem_exclusive_R12: assert (!(mem_rd_o && mem_wr_o))
            else $error("memory read and write both requested");
         assert_idle_dst_zero_R2: assert (reg_we_o || dst_reg_o == '0)
            else $error("destination nonzero without a write");
      end
   end
endmodule

// File: tb/tb_insn_decoder.sv
module tb_insn_decoder;
   localparam int LINK_MIN = 30;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] instr = '0;
   int          n_checks = 0;
   int          n_errors = 0;
   bit          finished = 1'b0;

   always #10 clk = ~clk;

   logic [5:0]  a_op, b_op, a_fn, b_fn;
   logic [4:0]  a_rs, a_rt, a_rd, a_sh, b_rs, b_rt, b_rd, b_sh;
   logic [3:0]  a_alu, b_alu;
   logic [4:0]  a_dst, b_dst;
   logic [1:0]  a_msz, b_msz, a_ext, b_ext;
   logic [31:0] a_imm, b_imm;
   logic        a_we, a_mrd, a_mwr, a_br, a_bne, a_j, a_l, a_jr, a_ill;
   logic        b_we, b_mrd, b_mwr, b_br, b_bne, b_j, b_l, b_jr, b_ill;

   insn_decoder dut (
      .instr_i(instr), .opcode_o(a_op), .rs_o(a_rs), .rt_o(a_rt), .rd_o(a_rd),
      .shamt_o(a_sh), .funct_o(a_fn), .alu_op_o(a_alu), .reg_we_o(a_we),
      .dst_reg_o(a_dst), .mem_rd_o(a_mrd), .mem_wr_o(a_mwr), .mem_size_o(a_msz),
      .branch_o(a_br), .branch_ne_o(a_bne), .jump_o(a_j), .link_o(a_l),
      .jreg_o(a_jr), .ext_mode_o(a_ext), .imm_o(a_imm), .illegal_o(a_ill)
   );

   insn_decoder #(.HAS_UNSIGNED_CMP(1'b0), .LINK_REG(LINK_MIN)) dut_min (
      .instr_i(instr), .opcode_o(b_op), .rs_o(b_rs), .rt_o(b_rt), .rd_o(b_rd),
      .shamt_o(b_sh), .funct_o(b_fn), .alu_op_o(b_alu), .reg_we_o(b_we),
      .dst_reg_o(b_dst), .mem_rd_o(b_mrd), .mem_wr_o(b_mwr), .mem_size_o(b_msz),
      .branch_o(b_br), .branch_ne_o(b_bne), .jump_o(b_j), .link_o(b_l),
      .jreg_o(b_jr), .ext_mode_o(b_ext), .imm_o(b_imm), .illegal_o(b_ill)
   );

   // Packed layout: alu, we, dst, mrd, mwr, size, br, bne, j, link, jreg, ext, imm, illegal
   function automatic logic [53:0] model(input logic [31:0] w, input bit uns, input logic [4:0] lnk);
      logic [3:0] alu = 4'd0;
      logic [4:0] dst = 5'd0;
      logic [1:0] msz = 2'd0, ext = 2'd0;
      logic       we = 0, mrd = 0, mwr = 0, br = 0, bne = 0, j = 0, l = 0, jr = 0, ill = 0;
      logic [31:0] imm;
      case (w[31:26])
         6'h00: begin
            we = 1; dst = w[15:11];
            case (w[5:0])
               6'h20: alu = 0;
               6'h22: alu = 1;
               6'h24: alu = 2;
               6'h25: alu = 3;
               6'h27: alu = 4;
               6'h2A: alu = 5;
               6'h2B: if (uns) alu = 6; else ill = 1;
               6'h08: begin we = 0; dst = 0; jr = 1; end
               default: ill = 1;
            endcase
         end
         6'h08: begin we = 1; dst = w[20:16]; end
         6'h0A: begin we = 1; dst = w[20:16]; alu = 5; end
         6'h0B: begin we = 1; dst = w[20:16]; alu = 6; if (!uns) ill = 1; end
         6'h0C: begin we = 1; dst = w[20:16]; alu = 2; ext = 1; end
         6'h0D: begin we = 1; dst = w[20:16]; alu = 3; ext = 1; end
         6'h0F: begin we = 1; dst = w[20:16]; alu = 7; ext = 2; end
         6'h23: begin we = 1; dst = w[20:16]; mrd = 1; msz = 2; end
         6'h2B: begin mwr = 1; msz = 2; end
         6'h04: begin br = 1; alu = 1; end
         6'h05: begin br = 1; bne = 1; alu = 1; end
         6'h02: j = 1;
         6'h03: begin j = 1; l = 1; we = 1; dst = lnk; end
         default: ill = 1;
      endcase
      if (ill) begin
         alu = 0; dst = 0; msz = 0; ext = 0;
         we = 0; mrd = 0; mwr = 0; br = 0; bne = 0; j = 0; l = 0; jr = 0;
      end
      case (ext)
         2'd1:    imm = {16'h0000, w[15:0]};
         2'd2:    imm = {w[15:0], 16'h0000};
         default: imm = {{16{w[15]}}, w[15:0]};
      endcase
      return {alu, we, dst, mrd, mwr, msz, br, bne, j, l, jr, ext, imm, ill};
   endfunction

   typedef struct {
      logic [31:0] w;
      logic [53:0] exp_a;
      logic [53:0] exp_b;
      string       req;
   } item_t;

   item_t sb_q[$];

   function automatic logic [31:0] rform(input logic [4:0] s, t, d, sh, input logic [5:0] fn);
      return {6'h00, s, t, d, sh, fn};
   endfunction

   function automatic logic [31:0] iform(input logic [5:0] op, input logic [4:0] s, t, input logic [15:0] im);
      return {op, s, t, im};
   endfunction

   task automatic drive(input logic [31:0] w, input string req);
      item_t it;
      @(posedge clk);
      #1;
      instr    = w;
      it.w     = w;
      it.exp_a = model(w, 1'b1, 5'd31);
      it.exp_b = model(w, 1'b0, 5'(LINK_MIN));
      it.req   = req;
      sb_q.push_back(it);
   endtask

   // Monitor: compares at the falling edge after each drive
   always @(negedge clk) begin
      if (sb_q.size() > 0) begin
         item_t it;
         logic [53:0] act_a, act_b;
         it = sb_q.pop_front();
         act_a = {a_alu, a_we, a_dst, a_mrd, a_mwr, a_msz, a_br, a_bne, a_j, a_l, a_jr, a_ext, a_imm, a_ill};
         act_b = {b_alu, b_we, b_dst, b_mrd, b_mwr, b_msz, b_br, b_bne, b_j, b_l, b_jr, b_ext, b_imm, b_ill};
         n_checks++;
         if ({a_op, a_rs, a_rt, a_rd, a_sh, a_fn} !== it.w) begin
            n_errors++;
            $display("FAIL R1 fields of %h: actual %h expected %h", it.w,
                     {a_op, a_rs, a_rt, a_rd, a_sh, a_fn}, it.w);
         end
         n_checks++;
         if (act_a !== it.exp_a) begin
            n_errors++;
            $display("FAIL %s dut word %h: actual %h expected %h", it.req, it.w, act_a, it.exp_a);
         end
         n_checks++;
         if (act_b !== it.exp_b) begin
            n_errors++;
            $display("FAIL %s dut_min word %h: actual %h expected %h", it.req, it.w, act_b, it.exp_b);
         end
         n_checks++;
         if (a_mrd && a_mwr) begin
            n_errors++;
            $display("FAIL R12 word %h: actual rd=%b wr=%b expected not both", it.w, a_mrd, a_mwr);
         end
      end
   end

   initial begin
      #(200000 * 20);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      drive(32'h0000_0000, "R10 reset");
      repeat (2) @(posedge clk);
      rst = 1'b0;
      drive(rform(5'd8, 5'd20, 5'd16, 5'd0, 6'h20), "R2 add");
      drive(rform(5'd18, 5'd19, 5'd17, 5'd0, 6'h22), "R2 sub");
      drive(rform(5'd10, 5'd18, 5'd17, 5'd3, 6'h24), "R2 and");
      drive(rform(5'd1, 5'd2, 5'd3, 5'd0, 6'h25), "R2 or");
      drive(rform(5'd14, 5'd19, 5'd18, 5'd0, 6'h27), "R2 nor");
      drive(rform(5'd18, 5'd19, 5'd17, 5'd0, 6'h2A), "R2 slt");
      drive(rform(5'd4, 5'd5, 5'd6, 5'd0, 6'h2B), "R2 R11 sltu");
      drive(rform(5'd31, 5'd0, 5'd0, 5'd0, 6'h08), "R9 jr");
      drive(iform(6'h08, 5'd17, 5'd13, 16'hFF82), "R3 addi negative");
      drive(iform(6'h08, 5'd17, 5'd13, 16'h0082), "R3 addi positive");
      drive(iform(6'h0A, 5'd3, 5'd9, 16'hFFFD), "R3 slti");
      drive(iform(6'h0B, 5'd3, 5'd9, 16'h8000), "R3 R11 sltiu");
      drive(iform(6'h0C, 5'd19, 5'd9, 16'h8001), "R4 andi");
      drive(iform(6'h0D, 5'd4, 5'd11, 16'hF07B), "R4 ori");
      drive(iform(6'h0F, 5'd0, 5'd8, 16'h8F12), "R5 lui");
      drive(iform(6'h23, 5'd17, 5'd21, 16'h0004), "R6 lw");
      drive(iform(6'h23, 5'd29, 5'd8, 16'hFFF4), "R6 lw negative");
      drive(iform(6'h2B, 5'd20, 5'd16, 16'h0010), "R6 sw");
      drive(iform(6'h04, 5'd21, 5'd17, 16'h0014), "R7 beq");
      drive(iform(6'h05, 5'd16, 5'd17, 16'hFFF3), "R7 bne");
      drive({6'h02, 26'h000_0088}, "R8 j");
      drive({6'h03, 26'h3FF_FFFF}, "R8 jal");
      drive(32'hFC00_FFFF, "R10 opcode 0x3F");
      drive(iform(6'h01, 5'd1, 5'd2, 16'h1234), "R10 opcode 0x01");
      drive(rform(5'd1, 5'd2, 5'd3, 5'd0, 6'h21), "R10 funct 0x21");
      drive(rform(5'd1, 5'd2, 5'd3, 5'd7, 6'h00), "R10 funct 0x00");
      repeat (3) @(posedge clk);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule